// File: doc/BRIEF.md
# Oversampling UART Receiver with Noise Detection

This block turns an asynchronous serial line into characters. It advances only on a receive-timing tick (`rt_tick`) that an external baud generator supplies at sixteen times the bit rate. Every bit slot is therefore sixteen tick phases long, numbered 1 to 16. While idle, the receiver watches for a falling edge. It then checks that the start bit is genuine. After that it shifts in 8 or 9 data bits, least significant first, and finally decides the stop bit.

Each bit is sampled at phases 8, 9 and 10 and resolved by a two-of-three vote. If the three samples of any bit in a character disagree, the character is marked noisy. A stop bit that resolves low is a framing error. A character whose data and stop bits are all low is also reported as a break. After either of these, the receiver waits for the line to go high before it looks for the next start. A falling edge inside a character realigns the phase count, so a transmitter that runs somewhat fast or slow still gets centred samples.

The status flags are sticky. Software, or a register wrapper, acknowledges them with a one-cycle clear strobe.

Top module: `uart_rx_os`

## Requirements
- R1: A start is taken only on a tick where `rxd` is 0 and the previous tick saw 1. If the start bit then votes 1 at phases 8/9/10, the receiver goes back to hunting and reports no character.
- R2: Each bit's value is the majority of the line samples taken on the ticks at phases 8, 9 and 10 of that bit, where the start-edge tick is phase 1.
- R3: If the three samples of any bit in a character (start, data or stop) do not all agree, `err_noise` is set when that character completes.
- R4: Data bits arrive least significant first. In 8-bit mode `rx_data` holds the eight data bits and `rx_bit9` reads 0.
- R5: With `nine_bit`=1 at the start edge, nine data bits are received. The first eight go to `rx_data` and the ninth goes to `rx_bit9`. Completion comes on the 170th tick, counting the start-edge tick as the first.
- R6: In 8-bit mode, completion comes on the 154th tick, counting the start-edge tick as the first. `rx_full` is 1 from the clock edge of that tick onward.
- R7: A stop bit that votes 0 sets `err_frame` on the same edge that sets `rx_full`. The received data is still delivered.
- R8: If all data bits and the stop bit vote 0, both `rx_break` and `err_frame` are set. No new start is taken until the line has been seen high.
- R9: A falling edge inside a character at phases 2–7 restarts the current bit at phase 1. One at phases 11–16 begins the next bit at phase 1. Characters sent at 15 or 17 ticks per bit, with alternating data bits, are therefore received without error.
- R10: After reset all four flags are 0. The flags only accumulate until `flag_clr` is pulsed, and `flag_clr` clears them. If `flag_clr` coincides with a completion, `rx_full` stays 1 and the error flags take only the new character's values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_tick | input | 1 | Receive-timing enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high, already synchronous to clk |
| nine_bit | input | 1 | 1 selects 9 data bits, sampled at the start edge |
| flag_clr | input | 1 | One-cycle strobe clearing the status flags |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Ninth data bit in 9-bit mode, else 0 |
| rx_full | output | 1 | A character has completed |
| err_noise | output | 1 | Sample disagreement in a received character |
| err_frame | output | 1 | Stop bit resolved low |
| rx_break | output | 1 | All-zero character without a stop bit |

## Verification
On every cycle, the assertions check these rules:
- the phase count stays within 1..16;
- each completion raises `rx_full`, and raises `err_frame` when the stop vote is low;
- a noisy character leaves `err_noise` set;
- a break always comes with a framing error, and no error flag stands without `rx_full`;
- a clear without a completion empties the flags;
- the receiver stays parked while the line is low after a bad stop bit.

Only the bench scenarios can show the rest:
- which bit lands where in the data;
- that completion lands exactly on tick 154 or 170;
- that one corrupted sample is outvoted while two flip the bit;
- that a short low glitch produces no character;
- that resynchronisation rescues characters sent at 15 or 17 ticks per bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_HUNT      = 2'd0,
    RX_FRAME     = 2'd1,
    RX_WAIT_HIGH = 2'd2
  } rx_state_t;

  // two-of-three decision
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // samples of one bit not unanimous
  function automatic logic split3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction

  // bit slot index of the stop bit: slot 0 is the start bit
  function automatic int unsigned stop_slot(input logic nine, input int unsigned data_w);
    return nine ? data_w + 2 : data_w + 1;
  endfunction

endpackage

// File: rtl/uart_rx_phase.sv
module uart_rx_phase #(
  parameter int unsigned RT_PER_BIT = 16,
  parameter int unsigned SMP_FIRST  = 8,
  parameter int unsigned PH_W       = 5,
  parameter int unsigned IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rt_tick,
  input  logic             load,
  input  logic             run,
  input  logic             fall,
  output logic [IDX_W-1:0] bit_idx,
  output logic             samp_a,
  output logic             samp_b,
  output logic             vote_now
);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
  localparam logic [PH_W-1:0] PH_TWO  = PH_W'(2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(RT_PER_BIT);
  localparam logic [PH_W-1:0] PH_S1   = PH_W'(SMP_FIRST);
  localparam logic [PH_W-1:0] PH_S2   = PH_W'(SMP_FIRST + 1);
  localparam logic [PH_W-1:0] PH_S3   = PH_W'(SMP_FIRST + 2);

  // ph/idx hold the phase and slot of the most recently processed tick
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;
  logic [PH_W-1:0]  cur_ph;
  logic [IDX_W-1:0] cur_idx;
  logic             resync_same;
  logic             resync_next;

  always_comb begin
    cur_ph  = (ph == PH_LAST) ? PH_ONE : ph + PH_ONE;
    cur_idx = (ph == PH_LAST) ? idx + IDX_W'(1) : idx;
  end

  assign resync_same = run && fall && (cur_ph >= PH_TWO) && (cur_ph < PH_S1);
  assign resync_next = run && fall && (cur_ph > PH_S3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_ONE;
      idx <= '0;
    end else if (rt_tick) begin
      if (load) begin
        ph  <= PH_ONE;
        idx <= '0;
      end else if (run) begin
        if (resync_same) begin
          ph  <= PH_ONE;
          idx <= cur_idx;
        end else if (resync_next) begin
          ph  <= PH_ONE;
          idx <= cur_idx + IDX_W'(1);
        end else begin
          ph  <= cur_ph;
          idx <= cur_idx;
        end
      end
    end
  end

  assign bit_idx  = cur_idx;
  assign samp_a   = rt_tick && run && (cur_ph == PH_S1);
  assign samp_b   = rt_tick && run && (cur_ph == PH_S2);
  assign vote_now = rt_tick && run && (cur_ph == PH_S3);

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph >= PH_ONE) && (ph <= PH_LAST));

  assert_resync_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_tick && !load && resync_same) |=> (ph == PH_ONE));

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_a,
  input  logic samp_b,
  input  logic rxd,
  output logic bit_val,
  output logic bit_noisy
);
  import uart_rx_pkg::*;

  logic s_a, s_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else begin
      if (samp_a) s_a <= rxd;
      if (samp_b) s_b <= rxd;
    end
  end

  // third sample is the live line on the deciding tick
  assign bit_val   = maj3(s_a, s_b, rxd);
  assign bit_noisy = split3(s_a, s_b, rxd);

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [DATA_W:0] sh,
  output logic          all_zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      all_zero <= 1'b1;
    end else if (clear) begin
      sh       <= '0;
      all_zero <= 1'b1;
    end else if (shift_en) begin
      // LSB first: each new bit enters at the top and moves down
      sh       <= {bit_in, sh[DATA_W:1]};
      all_zero <= all_zero & ~bit_in;
    end
  end
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RT_PER_BIT = 16,
  parameter int unsigned SMP_FIRST  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_tick,
  input  logic              rxd,
  input  logic              nine_bit,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_full,
  output logic              err_noise,
  output logic              err_frame,
  output logic              rx_break
);
  import uart_rx_pkg::*;

  localparam int unsigned PH_W  = $clog2(RT_PER_BIT + 1);
  localparam int unsigned IDX_W = $clog2(DATA_W + 4);
  localparam logic [IDX_W-1:0] STOP_N = IDX_W'(stop_slot(1'b0, DATA_W));
  localparam logic [IDX_W-1:0] STOP_W = IDX_W'(stop_slot(1'b1, DATA_W));

  rx_state_t        state;
  logic             line_prev;
  logic             nine_q;
  logic             noise_acc;
  logic [IDX_W-1:0] bit_idx;
  logic             samp_a, samp_b, vote_now;
  logic             bit_val, bit_noisy;
  logic [DATA_W:0]  sh;
  logic             all_zero;

  // named internal events
  logic             fall;
  logic             start_edge;
  logic             in_frame;
  logic [IDX_W-1:0] stop_idx;
  logic             false_start;
  logic             data_vote;
  logic             done;
  logic             stop_bad;
  logic             char_noisy;
  logic             brk_now;

  assign fall        = !rxd && line_prev;
  assign in_frame    = (state == RX_FRAME);
  assign start_edge  = rt_tick && (state == RX_HUNT) && fall;
  assign stop_idx    = nine_q ? STOP_W : STOP_N;
  assign false_start = vote_now && (bit_idx == '0) && bit_val;
  assign data_vote   = vote_now && (bit_idx != '0) && (bit_idx < stop_idx);
  assign done        = vote_now && (bit_idx == stop_idx);
  assign stop_bad    = !bit_val;
  assign char_noisy  = noise_acc | bit_noisy;
  assign brk_now     = all_zero & stop_bad;

  uart_rx_phase #(
    .RT_PER_BIT(RT_PER_BIT), .SMP_FIRST(SMP_FIRST), .PH_W(PH_W), .IDX_W(IDX_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .load(start_edge),
    .run(in_frame), .fall(fall), .bit_idx(bit_idx),
    .samp_a(samp_a), .samp_b(samp_b), .vote_now(vote_now)
  );

  uart_rx_vote u_vote (
    .clk(clk), .rst_n(rst_n), .samp_a(samp_a), .samp_b(samp_b), .rxd(rxd),
    .bit_val(bit_val), .bit_noisy(bit_noisy)
  );

  uart_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(start_edge), .shift_en(data_vote),
    .bit_in(bit_val), .sh(sh), .all_zero(all_zero)
  );

  // line history and control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_HUNT;
      line_prev <= 1'b0;
      nine_q    <= 1'b0;
      noise_acc <= 1'b0;
    end else if (rt_tick) begin
      line_prev <= rxd;
      unique case (state)
        RX_HUNT: if (start_edge) begin
          state     <= RX_FRAME;
          nine_q    <= nine_bit;
          noise_acc <= 1'b0;
        end
        RX_FRAME: begin
          if (vote_now) noise_acc <= char_noisy;
          if (false_start)  state <= RX_HUNT;
          else if (done)    state <= stop_bad ? RX_WAIT_HIGH : RX_HUNT;
        end
        RX_WAIT_HIGH: if (rxd) state <= RX_HUNT;
        default: state <= RX_HUNT;
      endcase
    end
  end

  // result and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_full   <= 1'b0;
      err_noise <= 1'b0;
      err_frame <= 1'b0;
      rx_break  <= 1'b0;
    end else if (done) begin
      rx_data   <= nine_q ? sh[DATA_W-1:0] : sh[DATA_W:1];
      rx_bit9   <= nine_q & sh[DATA_W];
      rx_full   <= 1'b1;
      err_noise <= (err_noise & ~flag_clr) | char_noisy;
      err_frame <= (err_frame & ~flag_clr) | stop_bad;
      rx_break  <= (rx_break  & ~flag_clr) | brk_now;
    end else if (flag_clr) begin
      rx_full   <= 1'b0;
      err_noise <= 1'b0;
      err_frame <= 1'b0;
      rx_break  <= 1'b0;
    end
  end

  assert_full_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full);

  assert_frame_on_bad_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_bad) |=> err_frame);

  assert_noise_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && char_noisy) |=> err_noise);

  assert_break_is_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |-> err_frame);

  assert_wait_for_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_WAIT_HIGH && !rxd) |=> (state == RX_WAIT_HIGH));

  assert_flags_need_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_noise || err_frame || rx_break) |-> rx_full);

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !done) |=> (!rx_full && !err_noise && !err_frame && !rx_break));

  assert_false_start_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (false_start && !rx_full) |=> !rx_full);

endmodule

// File: tb/uart_rx_os_bench.sv
module uart_rx_os_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rt_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       nine_bit = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_full, err_noise, err_frame, rx_break;

  int n_checks = 0;
  int n_fail   = 0;
  int done_t   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_rx_os u_uart_rx_os (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd(rxd), .nine_bit(nine_bit),
    .flag_clr(flag_clr), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
    .err_noise(err_noise), .err_frame(err_frame), .rx_break(rx_break)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // one timing tick every other clock
  task automatic tick1(input logic v, input logic clr_now);
    @(negedge clk);
    rxd = v; rt_tick = 1'b1; flag_clr = clr_now;
    @(negedge clk);
    rt_tick = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick1(1'b1, 1'b0);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // bench's own model of the line: slot 0 start, then data LSB first, then stop
  function automatic logic line_at(input int t, input logic [8:0] d, input logic nine,
                                   input int tpb, input logic stopv);
    int b = (t - 1) / tpb;
    int nb = nine ? 9 : 8;
    if (b == 0) return 1'b0;
    if (b <= nb) return d[b-1];
    return stopv;
  endfunction

  function automatic int finish_tick(input logic nine);
    return (nine ? 10 : 9) * 16 + 10;
  endfunction

  task automatic send_frame(input logic [8:0] d, input logic nine, input int tpb,
                            input logic stopv, input int f1, input int f2, input int clr_t);
    int total = ((nine ? 9 : 8) + 2) * tpb;
    nine_bit = nine;
    done_t = 0;
    for (int t = 1; t <= total; t++) begin
      logic v = line_at(t, d, nine, tpb, stopv);
      if (t == f1 || t == f2) v = ~v;
      tick1(v, (t == clr_t));
      if (rx_full && done_t == 0) done_t = t;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rx_full == 0 && err_noise == 0 && err_frame == 0 && rx_break == 0,
        "R10", "reset flags", {28'd0, rx_full, err_noise, err_frame, rx_break}, 0);
    idle(5);

    // R4 R6 clean 8-bit frame and completion tick
    send_frame(9'h0A5, 1'b0, 16, 1'b1, 0, 0, 0);
    chk(rx_data == 8'hA5 && rx_bit9 == 0, "R4", "8-bit data", {23'd0, rx_bit9, rx_data}, 32'hA5);
    chk(done_t == finish_tick(1'b0), "R6", "8-bit completion tick", done_t, finish_tick(1'b0));
    chk(!err_noise && !err_frame && !rx_break, "R6", "clean flags",
        {29'd0, err_noise, err_frame, rx_break}, 0);
    idle(4); clear_flags();

    // R5 nine-bit frame
    send_frame(9'h13C, 1'b1, 16, 1'b1, 0, 0, 0);
    chk(rx_data == 8'h3C && rx_bit9 == 1, "R5", "9-bit data", {23'd0, rx_bit9, rx_data}, 32'h13C);
    chk(done_t == finish_tick(1'b1), "R5", "9-bit completion tick", done_t, finish_tick(1'b1));
    idle(4); clear_flags();

    // R3 one corrupted sample at phase 9 of slot 3: outvoted, noise flagged
    send_frame(9'h03C, 1'b0, 16, 1'b1, 3 * 16 + 9, 0, 0);
    chk(rx_data == 8'h3C, "R2", "single flip outvoted", rx_data, 32'h3C);
    chk(err_noise == 1, "R3", "noise flag", err_noise, 1);
    idle(4); clear_flags();

    // R2 two corrupted samples (phases 8,9 of slot 3 = data bit 2): bit inverted
    send_frame(9'h03C, 1'b0, 16, 1'b1, 3 * 16 + 8, 3 * 16 + 9, 0);
    chk(rx_data == 8'h38, "R2", "double flip wins vote", rx_data, 32'h38);
    chk(err_noise == 1, "R3", "noise on double flip", err_noise, 1);
    idle(4); clear_flags();

    // R7 low stop bit
    send_frame(9'h0A3, 1'b0, 16, 1'b0, 0, 0, 0);
    chk(err_frame == 1 && rx_break == 0, "R7", "framing without break",
        {30'd0, err_frame, rx_break}, 32'h2);
    chk(done_t == finish_tick(1'b0) && rx_data == 8'hA3, "R7", "frame flag with full, data kept",
        {done_t[15:0], 8'd0, rx_data}, {16'(finish_tick(1'b0)), 16'h00A3});
    idle(4); clear_flags();

    // R8 break then line held low: no new character until high
    send_frame(9'h000, 1'b0, 16, 1'b0, 0, 0, 0);
    chk(err_frame == 1 && rx_break == 1, "R8", "break flags", {30'd0, err_frame, rx_break}, 32'h3);
    clear_flags();
    for (int i = 0; i < 60; i++) tick1(1'b0, 1'b0);
    chk(rx_full == 0, "R8", "no character while line low", rx_full, 0);
    idle(3);
    send_frame(9'h081, 1'b0, 16, 1'b1, 0, 0, 0);
    chk(rx_full == 1 && rx_data == 8'h81 && !err_frame, "R8", "recovers after high",
        {22'd0, rx_full, err_frame, rx_data}, 32'h281);
    idle(4); clear_flags();

    // R1 short low glitch: start votes 1, no character
    for (int i = 0; i < 5; i++) tick1(1'b0, 1'b0);
    idle(200);
    chk(rx_full == 0, "R1", "glitch rejected", rx_full, 0);
    send_frame(9'h05A, 1'b0, 16, 1'b1, 0, 0, 0);
    chk(rx_data == 8'h5A && done_t == finish_tick(1'b0), "R1", "hunt resumes after glitch",
        {done_t[15:0], 8'd0, rx_data}, {16'(finish_tick(1'b0)), 16'h005A});
    idle(4); clear_flags();

    // R9 slow and fast transmitters
    send_frame(9'h055, 1'b0, 17, 1'b1, 0, 0, 0);
    chk(rx_full && rx_data == 8'h55 && !err_noise && !err_frame, "R9", "slow 17 ticks/bit",
        {22'd0, err_noise, err_frame, rx_data}, 32'h55);
    idle(4); clear_flags();
    send_frame(9'h055, 1'b0, 15, 1'b1, 0, 0, 0);
    chk(rx_full && rx_data == 8'h55 && !err_noise && !err_frame, "R9", "fast 15 ticks/bit",
        {22'd0, err_noise, err_frame, rx_data}, 32'h55);
    idle(4); clear_flags();

    // R10 sticky accumulation and clear coinciding with completion
    send_frame(9'h0F0, 1'b0, 16, 1'b1, 2 * 16 + 9, 0, 0);
    idle(3);
    send_frame(9'h00F, 1'b0, 16, 1'b1, 0, 0, 0);
    chk(err_noise == 1 && rx_data == 8'h0F, "R10", "noise sticky across frames",
        {23'd0, err_noise, rx_data}, 32'h10F);
    idle(3);
    send_frame(9'h0C3, 1'b0, 16, 1'b1, 0, 0, finish_tick(1'b0));
    chk(rx_full == 1 && err_noise == 0 && rx_data == 8'hC3, "R10", "clear with completion",
        {22'd0, rx_full, err_noise, rx_data}, 32'h2C3);
    clear_flags();
    chk(rx_full == 0, "R10", "clear strobe", rx_full, 0);
    idle(4);

    // R4 R5 random clean characters
    for (int k = 0; k < 24; k++) begin
      logic [8:0] d = 9'($urandom);
      logic nine = 1'($urandom);
      send_frame(d, nine, 16, 1'b1, 0, 0, 0);
      chk(rx_full && rx_data == d[7:0] && rx_bit9 == (nine & d[8]) && !err_noise && !err_frame,
          nine ? "R5" : "R4", "random character",
          {21'd0, err_noise, err_frame, rx_bit9, rx_data}, {23'd0, nine & d[8], d[7:0]});
      idle(1 + int'($urandom_range(0, 20)));
      clear_flags();
    end

    wrap_up();
  end
endmodule